// File: doc/BRIEF.md
# Thermal Sensor Calibration Code Converter

This block translates between a temperature in degrees Celsius and the raw 8-bit code that an on-die thermal sensor produces. Each sensor has two fused trim bytes that are packed into a 32-bit trim word. The block picks them out and checks them against a lower and an upper limit. A trim value that fails the check is replaced from a default fuse word. The corrected pair is then used for every conversion that follows.

Conversions run one at a time over a start/done handshake. The caller picks the direction (temperature to code, or code to temperature) and one of three calibration modes:
- **Two-point:** linear interpolation between two calibration temperatures and the two trim values.
- **One-point:** a single offset derived from the first trim value and the first calibration temperature.
- **Fixed offset:** a constant offset with no trim.

The two-point mode needs a signed division, which an iterative divider performs over several cycles. The other modes finish in one cycle. A zero denominator produces an error indication instead of a result.

Top module: `tcal_conv`

## Requirements
- R1: A one-cycle pulse on `load_trim` captures the trim pair. The first trim value comes from `trim_word[7:0]` and the second from `trim_word[15:8]`. The corrected values appear on `trim_e1`/`trim_e2` after the next rising clock edge.
- R2: The first trim value is replaced by `dflt_word[7:0]` in three cases: it is zero, it is below `lim_min`, or it is above `lim_max`. Both limits are inclusive, so values equal to a limit are kept.
- R3: The second trim value is replaced by `dflt_word[15:8]` when it is zero. No range check is applied to it.
- R4: With `cal_mode` = 2 and `req_dir` = 0 (temperature to code), the result is (val − T1)·(E2 − E1)/(T2 − T1) + E1. The division is signed and truncates toward zero.
- R5: With `cal_mode` = 2 and `req_dir` = 1 (code to temperature), the result is (val − E1)·(T2 − T1)/(E2 − E1) + T1. The division is signed and truncates toward zero.
- R6: With `cal_mode` = 1, temperature to code gives val + E1 − T1, and code to temperature gives val − E1 + T1.
- R7: With `cal_mode` = 0 or 3, temperature to code gives val + `dflt_ofs`, and code to temperature gives val − `dflt_ofs`.
- R8: `done` is high for exactly one cycle per accepted request. `result` changes only in a cycle in which `done` is high.
- R9: `busy` is high from the cycle after a request is accepted up to and including its `done` cycle. A `req_start` seen while `busy` is high is ignored and yields no result.
- R10: In two-point mode a zero denominator (T2 = T1 when converting temperature to code, or E2 = E1 when converting code to temperature) raises `err` together with `done` and leaves `result` unchanged. `err` stays high until the next request is accepted.
- R11: After reset, `busy`, `done` and `err` are low, and `result`, `trim_e1` and `trim_e2` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trim_word | input | TRIM_W | Fused trim word; E1 in [7:0], E2 in [15:8] |
| dflt_word | input | 2*W | Default trim pair; low byte for E1, high byte for E2 |
| lim_min | input | W | Lowest accepted first trim value |
| lim_max | input | W | Highest accepted first trim value |
| load_trim | input | 1 | Capture and correct the trim pair |
| cal_t1 | input | W | First calibration temperature |
| cal_t2 | input | W | Second calibration temperature |
| dflt_ofs | input | W | Offset for fixed-offset mode |
| cal_mode | input | 2 | 0/3 fixed offset, 1 one-point, 2 two-point |
| req_start | input | 1 | Request strobe, taken only when idle |
| req_dir | input | 1 | 0 temperature to code, 1 code to temperature |
| req_val | input | W | Unsigned value to convert |
| busy | output | 1 | A conversion is in flight |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request hit a zero denominator |
| result | output | RES_W | Signed conversion result |
| trim_e1 | output | W | Corrected first trim value |
| trim_e2 | output | W | Corrected second trim value |

## Verification
The checker assumes that `cal_mode`, the calibration temperatures and the trim pair stay stable while a conversion is in flight. It also assumes that `load_trim` is pulsed only when the block is idle. The bench therefore waits for `busy` to fall before it changes any setting or reloads trims. Stray strobes are raised only while a two-point division is running, so that they land in a busy window on purpose.

// File: rtl/tcal_pkg.sv
package tcal_pkg;
   typedef enum logic [1:0] {
      CAL_FIXED = 2'd0,
      CAL_ONE   = 2'd1,
      CAL_TWO   = 2'd2,
      CAL_ALT   = 2'd3
   } cal_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DIV  = 2'd1,
      ST_FIN  = 2'd2
   } conv_state_e;
endpackage

// File: rtl/tcal_trim_fix.sv
module tcal_trim_fix #(
   parameter int W      = 8,
   parameter int TRIM_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [TRIM_W-1:0] trim_word,
   input  logic [2*W-1:0]    dflt_word,
   input  logic [W-1:0]      lim_min,
   input  logic [W-1:0]      lim_max,
   output logic [W-1:0]      e1,
   output logic [W-1:0]      e2
);
   localparam int LANES = 2;

   logic [W-1:0] fixed [LANES];
   logic [W-1:0] held  [LANES];

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [W-1:0] raw;
      logic [W-1:0] fallback;
      logic         reject;

      assign raw      = trim_word[g*W +: W];
      assign fallback = dflt_word[g*W +: W];

      if (g == 0) begin : g_ranged
         assign reject = (raw == '0) || (raw < lim_min) || (raw > lim_max);
      end else begin : g_zero_only
         assign reject = (raw == '0);
      end

      assign fixed[g] = reject ? fallback : raw;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            held[g] <= '0;
         end else if (load) begin
            held[g] <= fixed[g];
         end
      end
   end

   assign e1 = held[0];
   assign e2 = held[1];
endmodule

// File: rtl/tcal_sdiv.sv
module tcal_sdiv #(
   parameter int NW  = 18,
   parameter int DNW = 9
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic signed [NW-1:0]  num,
   input  logic signed [DNW-1:0] den,
   output logic                  fin,
   output logic signed [NW-1:0]  quo
);
   localparam int CW = $clog2(NW + 1);

   logic [NW-1:0]  q_sh;
   logic [DNW-1:0] rem;
   logic [DNW-1:0] dmag;
   logic [CW-1:0]  cnt;
   logic           run;
   logic           neg;

   logic [NW-1:0]  num_mag;
   logic [DNW-1:0] den_mag;
   logic [DNW:0]   trial;
   logic           ge;

   assign num_mag = num[NW-1]   ? NW'(-num)  : NW'(num);
   assign den_mag = den[DNW-1]  ? DNW'(-den) : DNW'(den);
   assign trial   = {rem, q_sh[NW-1]};
   assign ge      = trial >= {1'b0, dmag};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_sh <= '0;
         rem  <= '0;
         dmag <= '0;
         cnt  <= '0;
         run  <= 1'b0;
         neg  <= 1'b0;
         fin  <= 1'b0;
      end else if (start) begin
         q_sh <= num_mag;
         rem  <= '0;
         dmag <= den_mag;
         cnt  <= CW'(NW);
         run  <= 1'b1;
         neg  <= num[NW-1] ^ den[DNW-1];
         fin  <= 1'b0;
      end else if (run) begin
         q_sh <= {q_sh[NW-2:0], ge};
         rem  <= ge ? DNW'(trial - {1'b0, dmag}) : DNW'(trial);
         cnt  <= cnt - 1'b1;
         if (cnt == CW'(1)) begin
            run <= 1'b0;
            fin <= 1'b1;
         end
      end else begin
         fin <= 1'b0;
      end
   end

   assign quo = neg ? -$signed(q_sh) : $signed(q_sh);
endmodule

// File: rtl/tcal_conv.sv
module tcal_conv
   import tcal_pkg::*;
#(
   parameter int W      = 8,
   parameter int TRIM_W = 32,
   parameter int RES_W  = 2 * W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [TRIM_W-1:0] trim_word,
   input  logic [2*W-1:0]   dflt_word,
   input  logic [W-1:0]     lim_min,
   input  logic [W-1:0]     lim_max,
   input  logic             load_trim,
   input  logic [W-1:0]     cal_t1,
   input  logic [W-1:0]     cal_t2,
   input  logic [W-1:0]     dflt_ofs,
   input  logic [1:0]       cal_mode,
   input  logic             req_start,
   input  logic             req_dir,
   input  logic [W-1:0]     req_val,
   output logic             busy,
   output logic             done,
   output logic             err,
   output logic [RES_W-1:0] result,
   output logic [W-1:0]     trim_e1,
   output logic [W-1:0]     trim_e2
);
   localparam int DW = W + 1;
   localparam int NW = 2 * DW;

   if (W < 2) begin : g_bad_width
      $error("tcal_conv: W must be at least 2");
   end
   if (TRIM_W < 2 * W) begin : g_bad_trim
      $error("tcal_conv: TRIM_W must hold two trim fields");
   end
   if (RES_W < NW) begin : g_bad_res
      $error("tcal_conv: RES_W too narrow for the quotient");
   end

   conv_state_e state;
   cal_mode_e   mode;
   logic        accept;

   logic signed [DW-1:0]    s_val, s_t1, s_t2, s_e1, s_e2;
   logic signed [DW-1:0]    dt_v, dt_span, de_v, de_span;
   logic signed [NW-1:0]    num;
   logic signed [DW-1:0]    den;
   logic signed [DW-1:0]    base;
   logic signed [RES_W-1:0] x_val, x_e1, x_t1, x_ofs, direct;
   logic signed [RES_W-1:0] base_q;
   logic signed [NW-1:0]    quo;
   logic                    div_fin;
   logic                    div_go;

   tcal_trim_fix #(.W(W), .TRIM_W(TRIM_W)) u_trim (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_trim),
      .trim_word (trim_word),
      .dflt_word (dflt_word),
      .lim_min   (lim_min),
      .lim_max   (lim_max),
      .e1        (trim_e1),
      .e2        (trim_e2)
   );

   assign mode   = cal_mode_e'(cal_mode);
   assign accept = (state == ST_IDLE) && req_start;

   assign s_val = $signed({1'b0, req_val});
   assign s_t1  = $signed({1'b0, cal_t1});
   assign s_t2  = $signed({1'b0, cal_t2});
   assign s_e1  = $signed({1'b0, trim_e1});
   assign s_e2  = $signed({1'b0, trim_e2});

   assign dt_v    = s_val - s_t1;
   assign dt_span = s_t2 - s_t1;
   assign de_v    = s_val - s_e1;
   assign de_span = s_e2 - s_e1;

   always_comb begin
      if (!req_dir) begin
         num  = NW'(dt_v) * NW'(de_span);
         den  = dt_span;
         base = s_e1;
      end else begin
         num  = NW'(de_v) * NW'(dt_span);
         den  = de_span;
         base = s_t1;
      end
   end

   assign x_val = $signed({{(RES_W-W){1'b0}}, req_val});
   assign x_e1  = $signed({{(RES_W-W){1'b0}}, trim_e1});
   assign x_t1  = $signed({{(RES_W-W){1'b0}}, cal_t1});
   assign x_ofs = $signed({{(RES_W-W){1'b0}}, dflt_ofs});

   always_comb begin
      case (mode)
         CAL_ONE: direct = req_dir ? (x_val - x_e1 + x_t1) : (x_val + x_e1 - x_t1);
         default: direct = req_dir ? (x_val - x_ofs) : (x_val + x_ofs);
      endcase
   end

   assign div_go = accept && (mode == CAL_TWO) && (den != '0);

   tcal_sdiv #(.NW(NW), .DNW(DW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .start (div_go),
      .num   (num),
      .den   (den),
      .fin   (div_fin),
      .quo   (quo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         result <= '0;
         err    <= 1'b0;
         base_q <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  err <= 1'b0;
                  if (mode == CAL_TWO) begin
                     if (den == '0) begin
                        err   <= 1'b1;
                        state <= ST_FIN;
                     end else begin
                        base_q <= RES_W'(base);
                        state  <= ST_DIV;
                     end
                  end else begin
                     result <= direct;
                     state  <= ST_FIN;
                  end
               end
            end
            ST_DIV: begin
               if (div_fin) begin
                  result <= RES_W'(quo) + base_q;
                  state  <= ST_FIN;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy = (state != ST_IDLE);
   assign done = (state == ST_FIN);
endmodule

// File: rtl/tcal_conv_chk.sv
module tcal_conv_chk #(
   parameter int W      = 8,
   parameter int TRIM_W = 32,
   parameter int RES_W  = 2 * W + 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [TRIM_W-1:0] trim_word,
   input logic [2*W-1:0]    dflt_word,
   input logic [W-1:0]      lim_min,
   input logic [W-1:0]      lim_max,
   input logic              load_trim,
   input logic              req_start,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [RES_W-1:0]  result,
   input logic [W-1:0]      trim_e1,
   input logic [W-1:0]      trim_e2
);
   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(result) |-> done);

   assert_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && req_start) |=> busy);

   assert_stay_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);

   assert_err_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> done);

   assert_e1_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_trim) |-> (trim_e1 == $past(dflt_word[W-1:0])) ||
         (trim_e1 != '0 && trim_e1 >= $past(lim_min) && trim_e1 <= $past(lim_max)));

   assert_e2_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_trim) |-> (trim_e2 != '0) || ($past(dflt_word[2*W-1:W]) == '0));

   assert_e2_source_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(load_trim) |-> (trim_e2 == $past(trim_word[2*W-1:W])) ||
         (trim_e2 == $past(dflt_word[2*W-1:W])));
endmodule

bind tcal_conv tcal_conv_chk #(.W(W), .TRIM_W(TRIM_W), .RES_W(RES_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .trim_word (trim_word),
   .dflt_word (dflt_word),
   .lim_min   (lim_min),
   .lim_max   (lim_max),
   .load_trim (load_trim),
   .req_start (req_start),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .result    (result),
   .trim_e1   (trim_e1),
   .trim_e2   (trim_e2)
);

// File: tb/tcal_conv_tb.sv
module tcal_conv_tb;
   localparam int W     = 8;
   localparam int RES_W = 2 * W + 2;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [31:0]      trim_word = '0;
   logic [15:0]      dflt_word = 16'h6E32;
   logic [7:0]       lim_min = 8'd30;
   logic [7:0]       lim_max = 8'd120;
   logic             load_trim = 1'b0;
   logic [7:0]       cal_t1 = 8'd25;
   logic [7:0]       cal_t2 = 8'd85;
   logic [7:0]       dflt_ofs = 8'd50;
   logic [1:0]       cal_mode = 2'd2;
   logic             req_start = 1'b0;
   logic             req_dir = 1'b0;
   logic [7:0]       req_val = '0;
   logic             busy, done, err;
   logic [RES_W-1:0] result;
   logic [7:0]       trim_e1, trim_e2;

   tcal_conv #(.W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .trim_word(trim_word), .dflt_word(dflt_word),
      .lim_min(lim_min), .lim_max(lim_max), .load_trim(load_trim),
      .cal_t1(cal_t1), .cal_t2(cal_t2), .dflt_ofs(dflt_ofs), .cal_mode(cal_mode),
      .req_start(req_start), .req_dir(req_dir), .req_val(req_val),
      .busy(busy), .done(done), .err(err), .result(result),
      .trim_e1(trim_e1), .trim_e2(trim_e2)
   );

   always #10 clk = ~clk;

   int checks = 0;
   int errors = 0;
   int exp_e1 = 0;
   int exp_e2 = 0;
   int last_good = 0;
   bit finished = 1'b0;

   typedef struct {
      bit    e;
      int    r;
      string tag;
   } item_t;
   item_t sb[$];

   task automatic check(bit ok, string tag, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int fix_e1(int raw);
      if (raw == 0 || raw < int'(lim_min) || raw > int'(lim_max)) return int'(dflt_word[7:0]);
      return raw;
   endfunction

   function automatic int fix_e2(int raw);
      return (raw == 0) ? int'(dflt_word[15:8]) : raw;
   endfunction

   task automatic load(logic [31:0] w, string tag);
      while (busy) @(negedge clk);
      @(posedge clk) #2;
      trim_word = w;
      load_trim = 1'b1;
      @(posedge clk) #2;
      load_trim = 1'b0;
      exp_e1 = fix_e1(int'(w[7:0]));
      exp_e2 = fix_e2(int'(w[15:8]));
      @(negedge clk);
      check(int'(trim_e1) == exp_e1, {tag, " e1"}, int'(trim_e1), exp_e1);
      check(int'(trim_e2) == exp_e2, {tag, " e2"}, int'(trim_e2), exp_e2);
   endtask

   task automatic config_set(logic [1:0] m, logic [7:0] t2);
      while (busy) @(negedge clk);
      cal_mode = m;
      cal_t2   = t2;
   endtask

   task automatic do_req(bit dir, int v, string tag);
      item_t it;
      int t1, t2, num, den;
      t1 = int'(cal_t1);
      t2 = int'(cal_t2);
      it.e = 1'b0;
      it.tag = tag;
      if (cal_mode == 2'd2) begin
         num = dir ? (v - exp_e1) * (t2 - t1) : (v - t1) * (exp_e2 - exp_e1);
         den = dir ? (exp_e2 - exp_e1) : (t2 - t1);
         if (den == 0) begin
            it.e = 1'b1;
            it.r = last_good;
         end else begin
            it.r = num / den + (dir ? t1 : exp_e1);
         end
      end else if (cal_mode == 2'd1) begin
         it.r = dir ? v - exp_e1 + t1 : v + exp_e1 - t1;
      end else begin
         it.r = dir ? v - int'(dflt_ofs) : v + int'(dflt_ofs);
      end
      if (!it.e) last_good = it.r;
      sb.push_back(it);
      while (busy) @(negedge clk);
      @(posedge clk) #2;
      req_start = 1'b1;
      req_dir   = dir;
      req_val   = 8'(v);
      @(posedge clk) #2;
      req_start = 1'b0;
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && done) begin
         if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected done", 1, 0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(err == it.e, {it.tag, " err"}, int'(err), int'(it.e));
            check($signed(result) == it.r, {it.tag, " result"}, int'($signed(result)), it.r);
         end
      end
   end

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      check(1'b0, "watchdog", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(posedge clk);
      #2 rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      check(!busy && !done && !err, "R11 flags", int'({busy, done, err}), 0);
      check(result == '0, "R11 result", int'(result), 0);
      check(trim_e1 == 0 && trim_e2 == 0, "R11 trims", int'({trim_e1, trim_e2}), 0);

      // R1/R2/R3 trim correction
      load(32'h0000_7A37, "R1 plain");
      load(32'h0000_0000, "R3 R2 both zero");
      load(32'h0000_8014, "R2 below min");
      load(32'h0000_0080, "R2 above max R3");
      load(32'h0000_4C1E, "R2 at min");
      load(32'h0000_7878, "R2 at max");

      // R4/R5 two-point
      load(32'h0000_7A37, "R1 reload");
      config_set(2'd2, 8'd85);
      do_req(1'b0, 25,  "R4 t1");
      do_req(1'b0, 85,  "R4 t2");
      do_req(1'b0, 60,  "R4 mid");
      do_req(1'b0, 0,   "R4 negative num");
      do_req(1'b0, 255, "R4 top");
      do_req(1'b1, 55,  "R5 e1");
      do_req(1'b1, 122, "R5 e2");
      do_req(1'b1, 30,  "R5 below e1");
      do_req(1'b1, 200, "R5 high");

      // R9 strobes while busy are ignored
      do_req(1'b0, 70, "R9 first");
      @(posedge clk) #2;
      check(busy, "R9 busy", int'(busy), 1);
      req_start = 1'b1;
      req_val   = 8'd3;
      repeat (2) @(posedge clk) #2;
      req_start = 1'b0;

      // R6 one-point, R7 fixed offset
      config_set(2'd1, 8'd85);
      do_req(1'b0, 40, "R6 to code");
      do_req(1'b1, 40, "R6 to temp");
      do_req(1'b1, 0,  "R6 negative");
      config_set(2'd0, 8'd85);
      do_req(1'b0, 100, "R7 to code");
      do_req(1'b1, 10,  "R7 negative");
      config_set(2'd3, 8'd85);
      do_req(1'b0, 255, "R7 alt mode");

      // R10 divide by zero, then recovery
      config_set(2'd2, 8'd25);
      do_req(1'b0, 50, "R10 t span zero");
      config_set(2'd2, 8'd85);
      do_req(1'b0, 50, "R10 clear");
      load(32'h0000_7878, "R2 equal pair");
      do_req(1'b1, 90, "R10 e span zero");
      do_req(1'b0, 90, "R10 other dir ok");

      while (busy || sb.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R8 all results", sb.size(), 0);
      summary();
   end
endmodule